// File: doc/BRIEF.md
# Inhibitable Cycle and Retire Counters

This block holds two 64-bit event counters for a processor's machine-level control register space. The first advances on every clock cycle; the second advances once for each instruction the pipeline reports as retired. Software reaches each counter as two 32-bit halves through a plain register read/write port. It can also load either half, and the loaded value picks up the increment of that same cycle.

A counter-stop register holds one stop bit for each counter. A debug-halt level input freezes both counters, whatever the stop bits hold. A band of performance-counter and event-selector addresses is tied to zero: reads there return 0 and writes there have no effect. The read port is combinational and needs no handshake, so a read returns the counter value as it stands in that cycle.

Top module: `cyc_ret_counters`

## Requirements
- R1: After reset, both 64-bit counters and the stop register read as 0.
- R2: The cycle counter (low half at 0xB00, high half at 0xB80) increases by one on every clock edge while its stop bit is 0 and debug-halt is low.
- R3: The retire counter (low half at 0xB02, high half at 0xB82) increases by one on each edge where the retire strobe is high, its stop bit is 0 and debug-halt is low.
- R4: When an increment takes a low half from 0xFFFFFFFF to 0, the matching high half increases by one on the same edge.
- R5: The stop register at 0x320 is read/write. Bit 0 stops the cycle counter and bit 2 stops the retire counter. All its other bits read 0. A new stop value governs counting from the edge that follows the edge on which it was written.
- R6: While debug-halt is high, neither counter changes, unless software writes it.
- R7: A write of n to a counter half replaces that half on the edge. The increment of that cycle is added to n, so a read of a counting low half on the next cycle returns n+1. When the write targets the low half, the carry into the high half comes from n. When the write targets the high half, the high half becomes n plus any carry out of the current low half.
- R8: Addresses 0xB03–0xB1F, 0xB83–0xB9F and 0x323–0x33F read as 0. Writes to these addresses change no counter and no stop bit.
- R9: When the access strobe is low, the read data is 0 and no write takes place.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| csr_en | input | 1 | Register access strobe for this cycle |
| csr_we | input | 1 | The access is a write (only when csr_en is high) |
| csr_addr | input | 12 | Register address |
| csr_wdata | input | 32 | Write data |
| csr_rdata | output | 32 | Read data, combinational from the current state |
| retire | input | 1 | One instruction retired this cycle |
| dbg_halt | input | 1 | Debug-halt level; freezes both counters |

## Verification
A software write to a counter half can land in the same cycle as that counter's own increment. This also covers a write to a low half that ends in a carry out. The bench makes the two meet by writing a half while the counter runs, including writes of 0xFFFFFFFF to a low half. It also writes high halves while the low half sits at its wrap value, and drives random retire and halt patterns alongside random writes. Each result is judged by reading the half on the following cycle and comparing it with a bench model. The model adds the cycle's increment to the written value and derives the carry from the new low half.

// File: rtl/cnt_pkg.sv
package cnt_pkg;
  localparam int XLEN = 32;
  localparam int AW   = 12;
  localparam logic [AW-1:0] A_CYC_LO = 12'hB00;
  localparam logic [AW-1:0] A_CYC_HI = 12'hB80;
  localparam logic [AW-1:0] A_RET_LO = 12'hB02;
  localparam logic [AW-1:0] A_RET_HI = 12'hB82;
  localparam logic [AW-1:0] A_STOP   = 12'h320;
  localparam int STOP_CYC_BIT = 0;
  localparam int STOP_RET_BIT = 2;

  typedef struct packed {
    logic cyc_lo;
    logic cyc_hi;
    logic ret_lo;
    logic ret_hi;
    logic stop;
  } wr_sel_t;
endpackage

// File: rtl/cnt_pair.sv
module cnt_pair #(
  parameter int W = 64
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           inc,
  input  logic           wr_lo,
  input  logic           wr_hi,
  input  logic [W/2-1:0] wdata,
  output logic [W-1:0]   value
);
  localparam int H = W / 2;

  logic [H-1:0] lo_q, hi_q, lo_base, hi_base, lo_nx, hi_nx;
  logic         carry;

  always_comb begin
    lo_base = wr_lo ? wdata : lo_q;
    hi_base = wr_hi ? wdata : hi_q;
    {carry, lo_nx} = {1'b0, lo_base} + {{H{1'b0}}, inc};
    hi_nx = hi_base + {{(H-1){1'b0}}, carry};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q <= '0;
      hi_q <= '0;
    end else begin
      lo_q <= lo_nx;
      hi_q <= hi_nx;
    end
  end

  assign value = {hi_q, lo_q};

  AST_STEP_OR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_lo && !wr_hi) |=> value == $past(value) + {{(W-1){1'b0}}, $past(inc)}); // R4
  AST_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (!inc && !wr_lo && !wr_hi) |=> $stable(value)); // R6
  AST_WRITE_LO: assert property (@(posedge clk) disable iff (!rst_n)
    wr_lo |=> value[H-1:0] == $past(wdata) + {{(H-1){1'b0}}, $past(inc)}); // R7
endmodule

// File: rtl/cnt_stop_reg.sv
module cnt_stop_reg #(
  parameter int XW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr,
  input  logic [XW-1:0] wdata,
  output logic          stop_cyc,
  output logic          stop_ret
);
  import cnt_pkg::*;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stop_cyc <= 1'b0;
      stop_ret <= 1'b0;
    end else if (wr) begin
      stop_cyc <= wdata[STOP_CYC_BIT];
      stop_ret <= wdata[STOP_RET_BIT];
    end
  end

  AST_STOP_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    !wr |=> $stable(stop_cyc) && $stable(stop_ret)); // R5
endmodule

// File: rtl/cnt_rd_mux.sv
module cnt_rd_mux #(
  parameter int W  = 64,
  parameter int XW = 32
) (
  input  logic                  en,
  input  logic [cnt_pkg::AW-1:0] addr,
  input  logic [W-1:0]          cyc,
  input  logic [W-1:0]          ret,
  input  logic                  stop_cyc,
  input  logic                  stop_ret,
  output logic [XW-1:0]         rdata
);
  import cnt_pkg::*;
  localparam int H = W / 2;

  always_comb begin
    rdata = '0;
    if (en) begin
      unique case (addr)
        A_CYC_LO: rdata = cyc[H-1:0];
        A_CYC_HI: rdata = cyc[W-1:H];
        A_RET_LO: rdata = ret[H-1:0];
        A_RET_HI: rdata = ret[W-1:H];
        A_STOP: begin
          rdata[STOP_CYC_BIT] = stop_cyc;
          rdata[STOP_RET_BIT] = stop_ret;
        end
        default: rdata = '0;
      endcase
    end
  end

  always_comb begin
    if (en && addr == A_STOP)
      AST_STOP_RSV: assert (rdata[XW-1:3] == '0 && rdata[1] == 1'b0); // R5
  end
endmodule

// File: rtl/cyc_ret_counters.sv
module cyc_ret_counters (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        csr_en,
  input  logic        csr_we,
  input  logic [11:0] csr_addr,
  input  logic [31:0] csr_wdata,
  output logic [31:0] csr_rdata,
  input  logic        retire,
  input  logic        dbg_halt
);
  import cnt_pkg::*;
  localparam int CW = 2 * XLEN;

  wr_sel_t       wsel;
  logic          wr_any;
  logic          stop_cyc, stop_ret;
  logic          inc_cyc, inc_ret;
  logic [CW-1:0] cyc_val, ret_val;

  assign wr_any = csr_en && csr_we;

  always_comb begin
    wsel = '0;
    if (wr_any) begin
      wsel.cyc_lo = (csr_addr == A_CYC_LO);
      wsel.cyc_hi = (csr_addr == A_CYC_HI);
      wsel.ret_lo = (csr_addr == A_RET_LO);
      wsel.ret_hi = (csr_addr == A_RET_HI);
      wsel.stop   = (csr_addr == A_STOP);
    end
  end

  assign inc_cyc = !stop_cyc && !dbg_halt;
  assign inc_ret = retire && !stop_ret && !dbg_halt;

  cnt_stop_reg #(.XW(XLEN)) u_stop (
    .clk(clk), .rst_n(rst_n), .wr(wsel.stop), .wdata(csr_wdata),
    .stop_cyc(stop_cyc), .stop_ret(stop_ret)
  );

  cnt_pair #(.W(CW)) u_cyc (
    .clk(clk), .rst_n(rst_n), .inc(inc_cyc), .wr_lo(wsel.cyc_lo),
    .wr_hi(wsel.cyc_hi), .wdata(csr_wdata), .value(cyc_val)
  );

  cnt_pair #(.W(CW)) u_ret (
    .clk(clk), .rst_n(rst_n), .inc(inc_ret), .wr_lo(wsel.ret_lo),
    .wr_hi(wsel.ret_hi), .wdata(csr_wdata), .value(ret_val)
  );

  cnt_rd_mux #(.W(CW), .XW(XLEN)) u_rd (
    .en(csr_en), .addr(csr_addr), .cyc(cyc_val), .ret(ret_val),
    .stop_cyc(stop_cyc), .stop_ret(stop_ret), .rdata(csr_rdata)
  );

  AST_DBG_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    (dbg_halt && !wsel.cyc_lo && !wsel.cyc_hi && !wsel.ret_lo && !wsel.ret_hi)
    |=> $stable(cyc_val) && $stable(ret_val)); // R6
  AST_CYC_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    (!dbg_halt && !stop_cyc && !wsel.cyc_lo && !wsel.cyc_hi)
    |=> cyc_val == $past(cyc_val) + 64'd1); // R2
  AST_RET_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!retire && !wsel.ret_lo && !wsel.ret_hi) |=> $stable(ret_val)); // R3
  AST_NO_WR_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !csr_en |=> $stable({stop_cyc, stop_ret})); // R9
endmodule

// File: tb/sim_cyc_ret_counters.sv
module sim_cyc_ret_counters;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        csr_en = 1'b0, csr_we = 1'b0, retire = 1'b0, dbg_halt = 1'b0;
  logic [11:0] csr_addr = '0;
  logic [31:0] csr_wdata = '0;
  logic [31:0] csr_rdata;

  int total = 0, bad = 0;
  bit done = 0;
  logic [63:0] m_cyc = '0, m_ret = '0;
  logic        m_sc = 1'b0, m_sr = 1'b0;

  always #10 clk = ~clk;

  cyc_ret_counters u0 (.*);

  function automatic logic [63:0] nxt(logic [63:0] v, logic inc, logic wl,
                                      logic wh, logic [31:0] d);
    logic [31:0] lo, hi;
    logic [32:0] s;
    lo = wl ? d : v[31:0];
    hi = wh ? d : v[63:32];
    s  = {1'b0, lo} + {32'd0, inc};
    return {hi + {31'd0, s[32]}, s[31:0]};
  endfunction

  function automatic logic [31:0] exp_rd(logic [11:0] a);
    case (a)
      12'hB00: return m_cyc[31:0];
      12'hB80: return m_cyc[63:32];
      12'hB02: return m_ret[31:0];
      12'hB82: return m_ret[63:32];
      12'h320: return {29'd0, m_sr, 1'b0, m_sc};
      default: return 32'd0;
    endcase
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one cycle: drive at negedge, check read, advance model at the edge
  task automatic cyc(string req, logic en, logic we, logic [11:0] a,
                     logic [31:0] d, logic rt, logic dh, bit chk);
    logic ic, ir;
    @(negedge clk);
    csr_en = en; csr_we = we; csr_addr = a; csr_wdata = d;
    retire = rt; dbg_halt = dh;
    #2;
    if (chk) check(req, csr_rdata, en ? exp_rd(a) : 32'd0);
    @(posedge clk);
    ic = !m_sc && !dh;
    ir = rt && !m_sr && !dh;
    m_cyc = nxt(m_cyc, ic, en && we && a == 12'hB00, en && we && a == 12'hB80, d);
    m_ret = nxt(m_ret, ir, en && we && a == 12'hB02, en && we && a == 12'hB82, d);
    if (en && we && a == 12'h320) begin m_sc = d[0]; m_sr = d[2]; end
  endtask

  task automatic rd(string req, logic [11:0] a);
    cyc(req, 1'b1, 1'b0, a, 32'h0, 1'b0, 1'b0, 1'b1);
  endtask

  task automatic wr(logic [11:0] a, logic [31:0] d);
    cyc("", 1'b1, 1'b1, a, d, 1'b0, 1'b0, 1'b0);
  endtask

  initial begin
    #3_000_000;
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [11:0] pool [10];
    pool = '{12'hB00, 12'hB80, 12'hB02, 12'hB82, 12'h320,
             12'hB05, 12'hB9F, 12'h330, 12'h7B0, 12'hB1F};
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R1 reset state (hold counting via debug so values stay zero)
    cyc("R1", 1'b1, 1'b0, 12'hB00, 0, 1'b0, 1'b1, 1'b1);
    cyc("R1", 1'b1, 1'b0, 12'hB82, 0, 1'b0, 1'b1, 1'b1);
    cyc("R1", 1'b1, 1'b0, 12'h320, 0, 1'b0, 1'b1, 1'b1);
    // R2 cycle counter runs
    rd("R2", 12'hB00); rd("R2", 12'hB00);
    // R7 write n then read n+1
    wr(12'hB00, 32'h1000);
    rd("R7", 12'hB00);
    check("R7", csr_rdata, 32'h1001);
    // R4 wrap into high half
    wr(12'hB00, 32'hFFFF_FFFF);
    rd("R4", 12'hB80);
    check("R4", csr_rdata, 32'h1);
    // R7 high write with carry from current low
    wr(12'hB00, 32'hFFFF_FFFE);
    wr(12'hB80, 32'h55);
    rd("R7", 12'hB80);
    check("R7", csr_rdata, 32'h56);
    // R3 retire counts
    for (int i = 0; i < 5; i++) cyc("", 1'b0, 1'b0, 0, 0, 1'b1, 1'b0, 1'b0);
    rd("R3", 12'hB02);
    check("R3", csr_rdata, 32'd5);
    // R4 retire wrap
    wr(12'hB02, 32'hFFFF_FFFF);
    cyc("", 1'b0, 1'b0, 0, 0, 1'b1, 1'b0, 1'b0);
    rd("R4", 12'hB82);
    check("R4", csr_rdata, 32'd1);
    // R6 debug freeze
    wr(12'hB00, 32'h200);
    for (int i = 0; i < 4; i++) cyc("", 1'b0, 1'b0, 0, 0, 1'b1, 1'b1, 1'b0);
    cyc("R6", 1'b1, 1'b0, 12'hB00, 0, 1'b1, 1'b1, 1'b1);
    check("R6", csr_rdata, 32'h201);
    // R5 stop bits
    wr(12'h320, 32'hFFFF_FFFF);
    rd("R5", 12'h320);
    check("R5", csr_rdata, 32'h5);
    rd("R5", 12'hB00); rd("R5", 12'hB00);
    cyc("R5", 1'b1, 1'b0, 12'hB02, 0, 1'b1, 1'b0, 1'b1);
    cyc("R5", 1'b1, 1'b0, 12'hB02, 0, 1'b1, 1'b0, 1'b1);
    wr(12'h320, 32'h0);
    // R8 zero band
    wr(12'hB03, 32'hDEAD_BEEF); rd("R8", 12'hB03);
    wr(12'h33F, 32'hFFFF_FFFF); rd("R8", 12'h320);
    wr(12'hB9F, 32'h1234);      rd("R8", 12'hB80);
    // R9 idle strobe
    cyc("R9", 1'b0, 1'b1, 12'hB00, 32'h0, 1'b0, 1'b0, 1'b1);
    rd("R9", 12'hB00);
    // random mix
    for (int i = 0; i < 3000; i++) begin
      logic [11:0] a;
      logic        we;
      logic [31:0] d;
      a  = pool[$urandom_range(0, 9)];
      we = ($urandom_range(0, 5) == 0);
      d  = ($urandom_range(0, 3) == 0) ? 32'hFFFF_FFFF : $urandom;
      if (a == 12'h320) d = d & 32'hFFFF_FFF0 | {28'd0, 4'($urandom_range(0, 1) ? 0 : d[3:0])};
      cyc("R2 R3 R7 random", $urandom_range(0, 7) != 0, we, a, d,
          1'($urandom_range(0, 1)), $urandom_range(0, 9) == 0, 1'b1);
    end
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule